// File: doc/BRIEF.md
# Power-State Handshake Protocol Monitor

This block passively observes one power-state request channel. A controller raises a request wire and presents a target power level. The device answers by raising either an accept wire or a refuse wire. The monitor never drives the channel. It samples the four channel inputs every clock. It compares each one with its value from the previous sample and judges every edge against the levels the other handshake wires held in that previous sample.

Each rule breach sets its own sticky flag. A flag stays set until a clear input removes it. The monitor also follows the handshake through its phases and presents the current phase as a 3-bit code. Two wrapping counters record how many accepted handshakes and how many refused handshakes have run back to the idle phase. The block is meant to sit beside a power controller in simulation or in silicon, either as a debug aid or as a source of fault events.

Top module: `pwr_hs_monitor`

## Requirements
- R1: After a synchronous reset the phase output is 0 (idle), all rule flags are 0 and both counters are 0.
- R2: Flag bit 0 is set when the request wire rises while the accept or the refuse wire was high in the previous sample.
- R3: Flag bit 1 is set when the request wire falls unless exactly one of accept and refuse was high in the previous sample.
- R4: Flag bit 2 is set when the level bus changes value. It is not set if, in the previous sample, request, accept and refuse were all low. It is also not set if request and refuse were high with accept low.
- R5: Flag bit 3 is set when accept rises without request high and refuse low in the previous sample. Flag bit 4 is set when accept falls without request low and refuse low in the previous sample.
- R6: Flag bit 5 is set when refuse rises without request high and accept low in the previous sample. Flag bit 6 is set when refuse falls without request low and accept low in the previous sample.
- R7: Flag bit 7 is set whenever accept and refuse are sampled high together.
- R8: Flags are visible one clock after the offending sample and stay set until the clear input is sampled high. Clear resets all flags, but a breach detected in the same cycle as clear still sets its flag.
- R9: The accept path runs through the phase codes 0 (idle), 1 (requested), 2 (accepted) and 3 (completing), then back to 0. The accept counter increments on the return to 0.
- R10: The refuse path runs through the phase codes 0, 1, 4 (refused) and 5 (continuing), then back to 0. The refuse counter increments on the return to 0.
- R11: Accept and refuse sampled high together move the phase to code 6 (fault). The phase stays at 6 until request, accept and refuse are all sampled low, when it returns to 0 without changing either counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_req_i | input | 1 | Observed request wire |
| hs_lvl_i | input | LVL_W | Observed target power level |
| hs_ack_i | input | 1 | Observed accept wire |
| hs_nak_i | input | 1 | Observed refuse wire |
| err_clr_i | input | 1 | Clears all sticky rule flags |
| rule_err_o | output | 8 | Sticky flags, one per rule (bit map in R2 to R7) |
| phase_o | output | 3 | Current handshake phase code |
| acc_cnt_o | output | CNT_W | Count of completed accepted handshakes |
| den_cnt_o | output | CNT_W | Count of completed refused handshakes |

## Verification
The hardest situation to reach is an edge that starts from an arbitrary prior level combination. Some combinations, such as accept and refuse both high, cannot be reached without breaking a rule. The stimulus therefore drives each of the eight starting combinations and holds it for one cycle while clear is asserted. This leaves only the both-high flag that the held combination keeps forcing. The stimulus then moves to each of the eight ending combinations, with and without a level change, and compares all eight flags against rules worked out in the bench.

// File: rtl/pwr_hs_pkg.sv
package pwr_hs_pkg;

  localparam int NRULES = 8;

  // Flag bit positions, the bit map given in the requirements
  localparam int RULE_REQ_UP = 0;
  localparam int RULE_REQ_DN = 1;
  localparam int RULE_LVL    = 2;
  localparam int RULE_ACK_UP = 3;
  localparam int RULE_ACK_DN = 4;
  localparam int RULE_NAK_UP = 5;
  localparam int RULE_NAK_DN = 6;
  localparam int RULE_BOTH   = 7;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_REQ   = 3'd1,
    PH_ACC   = 3'd2,
    PH_DONE  = 3'd3,
    PH_DEN   = 3'd4,
    PH_CONT  = 3'd5,
    PH_FAULT = 3'd6
  } phase_e;

  typedef struct packed {
    logic req;
    logic ack;
    logic nak;
  } hs_bits_t;

endpackage

// File: rtl/pwr_hs_edge.sv
module pwr_hs_edge
  import pwr_hs_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  hs_bits_t         cur_i,
  input  logic [LVL_W-1:0] lvl_i,
  output hs_bits_t         prev_o,
  output logic             lvl_chg_o
);

  hs_bits_t         prev_q;
  logic [LVL_W-1:0] lvl_q;

  // During reset the history tracks the inputs, so the first sample after
  // reset is judged against a meaningful predecessor.
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= cur_i;
      lvl_q  <= lvl_i;
    end else begin
      prev_q <= cur_i;
      lvl_q  <= lvl_i;
    end
  end

  assign prev_o    = prev_q;
  assign lvl_chg_o = (lvl_i != lvl_q);

endmodule

// File: rtl/pwr_hs_rules.sv
module pwr_hs_rules
  import pwr_hs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  hs_bits_t          cur_i,
  input  hs_bits_t          prev_i,
  input  logic              lvl_chg_i,
  output logic [NRULES-1:0] err_o
);

  logic [NRULES-1:0] viol;
  logic [NRULES-1:0] err_q;
  logic req_up, req_dn, ack_up, ack_dn, nak_up, nak_dn;
  logic all_low_prev, refuse_hold_prev;

  always_comb begin
    req_up = cur_i.req & ~prev_i.req;
    req_dn = ~cur_i.req & prev_i.req;
    ack_up = cur_i.ack & ~prev_i.ack;
    ack_dn = ~cur_i.ack & prev_i.ack;
    nak_up = cur_i.nak & ~prev_i.nak;
    nak_dn = ~cur_i.nak & prev_i.nak;

    all_low_prev     = ~(prev_i.req | prev_i.ack | prev_i.nak);
    refuse_hold_prev = prev_i.req & prev_i.nak & ~prev_i.ack;

    viol              = '0;
    viol[RULE_REQ_UP] = req_up & (prev_i.ack | prev_i.nak);
    viol[RULE_REQ_DN] = req_dn & ~(prev_i.ack ^ prev_i.nak);
    viol[RULE_LVL]    = lvl_chg_i & ~(all_low_prev | refuse_hold_prev);
    viol[RULE_ACK_UP] = ack_up & ~(prev_i.req & ~prev_i.nak);
    viol[RULE_ACK_DN] = ack_dn & ~(~prev_i.req & ~prev_i.nak);
    viol[RULE_NAK_UP] = nak_up & ~(prev_i.req & ~prev_i.ack);
    viol[RULE_NAK_DN] = nak_dn & ~(~prev_i.req & ~prev_i.ack);
    viol[RULE_BOTH]   = cur_i.ack & cur_i.nak;
  end

  // One sticky flag per rule; a fresh breach outranks the clear.
  for (genvar i = 0; i < NRULES; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)          err_q[i] <= 1'b0;
      else if (viol[i]) err_q[i] <= 1'b1;
      else if (clr_i)   err_q[i] <= 1'b0;
    end
  end

  assign err_o = err_q;

endmodule

// File: rtl/pwr_hs_phase.sv
module pwr_hs_phase
  import pwr_hs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  hs_bits_t         cur_i,
  output logic [2:0]       phase_o,
  output logic [CNT_W-1:0] acc_cnt_o,
  output logic [CNT_W-1:0] den_cnt_o
);

  localparam int NCNT = 2;

  phase_e            ph_q, ph_d;
  logic [NCNT-1:0]   bump;
  logic [CNT_W-1:0]  cnt_q [NCNT];

  always_comb begin
    ph_d = ph_q;
    bump = '0;
    if (cur_i.ack && cur_i.nak) begin
      ph_d = PH_FAULT;
    end else begin
      unique case (ph_q)
        PH_IDLE:  if (cur_i.req && !cur_i.ack && !cur_i.nak) ph_d = PH_REQ;
        PH_REQ: begin
          if (cur_i.ack)      ph_d = PH_ACC;
          else if (cur_i.nak) ph_d = PH_DEN;
          else if (!cur_i.req) ph_d = PH_IDLE;
        end
        PH_ACC:   if (!cur_i.req) ph_d = PH_DONE;
        PH_DONE:  if (!cur_i.ack) begin ph_d = PH_IDLE; bump[0] = 1'b1; end
        PH_DEN:   if (!cur_i.req) ph_d = PH_CONT;
        PH_CONT:  if (!cur_i.nak) begin ph_d = PH_IDLE; bump[1] = 1'b1; end
        PH_FAULT: if (!cur_i.req && !cur_i.ack && !cur_i.nak) ph_d = PH_IDLE;
        default:  ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_IDLE;
    else     ph_q <= ph_d;
  end

  for (genvar c = 0; c < NCNT; c++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)          cnt_q[c] <= '0;
      else if (bump[c]) cnt_q[c] <= cnt_q[c] + 1'b1;
    end
  end

  assign phase_o   = ph_q;
  assign acc_cnt_o = cnt_q[0];
  assign den_cnt_o = cnt_q[1];

endmodule

// File: rtl/pwr_hs_monitor.sv
module pwr_hs_monitor
  import pwr_hs_pkg::*;
#(
  parameter int LVL_W = 4,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_req_i,
  input  logic [LVL_W-1:0]  hs_lvl_i,
  input  logic              hs_ack_i,
  input  logic              hs_nak_i,
  input  logic              err_clr_i,
  output logic [NRULES-1:0] rule_err_o,
  output logic [2:0]        phase_o,
  output logic [CNT_W-1:0]  acc_cnt_o,
  output logic [CNT_W-1:0]  den_cnt_o
);

  hs_bits_t cur, prev;
  logic     lvl_chg;

  assign cur = '{req: hs_req_i, ack: hs_ack_i, nak: hs_nak_i};

  pwr_hs_edge #(.LVL_W(LVL_W)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .cur_i     (cur),
    .lvl_i     (hs_lvl_i),
    .prev_o    (prev),
    .lvl_chg_o (lvl_chg)
  );

  pwr_hs_rules u_rules (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (err_clr_i),
    .cur_i     (cur),
    .prev_i    (prev),
    .lvl_chg_i (lvl_chg),
    .err_o     (rule_err_o)
  );

  pwr_hs_phase #(.CNT_W(CNT_W)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .cur_i     (cur),
    .phase_o   (phase_o),
    .acc_cnt_o (acc_cnt_o),
    .den_cnt_o (den_cnt_o)
  );

endmodule

// File: rtl/pwr_hs_monitor_chk.sv
module pwr_hs_monitor_chk
  import pwr_hs_pkg::*;
#(
  parameter int LVL_W = 4,
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              hs_req_i,
  input logic [LVL_W-1:0]  hs_lvl_i,
  input logic              hs_ack_i,
  input logic              hs_nak_i,
  input logic              err_clr_i,
  input logic [NRULES-1:0] rule_err_o,
  input logic [2:0]        phase_o,
  input logic [CNT_W-1:0]  acc_cnt_o,
  input logic [CNT_W-1:0]  den_cnt_o
);

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (phase_o == 3'd0 && rule_err_o == '0 && acc_cnt_o == '0 && den_cnt_o == '0));

  assert_req_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (hs_req_i && !$past(hs_req_i) && ($past(hs_ack_i) || $past(hs_nak_i))) |=> rule_err_o[RULE_REQ_UP]);

  assert_lvl_move_R4: assert property (@(posedge clk) disable iff (rst)
    (hs_lvl_i != $past(hs_lvl_i) && $past(hs_req_i) && !$past(hs_nak_i)) |=> rule_err_o[RULE_LVL]);

  assert_both_high_R7: assert property (@(posedge clk) disable iff (rst)
    (hs_ack_i && hs_nak_i) |=> rule_err_o[RULE_BOTH]);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !err_clr_i |=> (($past(rule_err_o) & ~rule_err_o) == '0));

  assert_accept_step_R9: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'd2) |=> (phase_o == 3'd2 || phase_o == 3'd3 || phase_o == 3'd6));

  assert_accept_count_R9: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'd3 && !hs_ack_i && !hs_nak_i) |=> (acc_cnt_o == CNT_W'($past(acc_cnt_o) + 1'b1)));

  assert_refuse_count_R10: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'd5 && !hs_nak_i && !hs_ack_i) |=> (den_cnt_o == CNT_W'($past(den_cnt_o) + 1'b1)));

  assert_fault_phase_R11: assert property (@(posedge clk) disable iff (rst)
    (hs_ack_i && hs_nak_i) |=> (phase_o == 3'd6));

  assert_phase_code_R11: assert property (@(posedge clk) disable iff (rst)
    phase_o != 3'd7);

endmodule

bind pwr_hs_monitor pwr_hs_monitor_chk #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_pwr_hs_monitor.sv
`timescale 1ns/1ps
module sim_pwr_hs_monitor;

  localparam int LVL_W = 4;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             hs_req = 1'b0, hs_ack = 1'b0, hs_nak = 1'b0, clr = 1'b0;
  logic [LVL_W-1:0] hs_lvl = '0;
  logic [7:0]       err;
  logic [2:0]       phase;
  logic [CNT_W-1:0] acc_cnt, den_cnt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pwr_hs_monitor #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .hs_req_i(hs_req), .hs_lvl_i(hs_lvl),
    .hs_ack_i(hs_ack), .hs_nak_i(hs_nak), .err_clr_i(clr),
    .rule_err_o(err), .phase_o(phase), .acc_cnt_o(acc_cnt), .den_cnt_o(den_cnt)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic drive(logic [2:0] v);
    hs_req = v[2];
    hs_ack = v[1];
    hs_nak = v[0];
  endtask

  function automatic string rtag(int b);
    case (b)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4: return "R5";
      5, 6: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Expected flags for a move from a={req,ack,nak} to b, with optional level change
  function automatic logic [7:0] exp_rules(logic [2:0] a, logic [2:0] b, bit lc);
    logic [7:0] e;
    e = '0;
    e[0] = !a[2] && b[2] && (a[1] || a[0]);
    e[1] = a[2] && !b[2] && !(a[1] != a[0]);
    e[2] = lc && !((a == 3'b000) || (a == 3'b101));
    e[3] = !a[1] && b[1] && !(a[2] && !a[0]);
    e[4] = a[1] && !b[1] && !(!a[2] && !a[0]);
    e[5] = !a[0] && b[0] && !(a[2] && !a[1]);
    e[6] = a[0] && !b[0] && !(!a[2] && !a[1]);
    e[7] = b[1] && b[0];
    return e;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    drive(3'b000);
    clr = 1'b0;
    repeat (3) step();
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1: reset state
    check("R1 phase", phase, 0);
    check("R1 flags", err, 0);
    check("R1 acc count", acc_cnt, 0);
    check("R1 refuse count", den_cnt, 0);

    // R9: accept path with level move alongside the request rise
    hs_lvl = 4'd5; hs_req = 1'b1; step(); check("R9 requested", phase, 1);
    hs_ack = 1'b1; step(); check("R9 accepted", phase, 2);
    hs_req = 1'b0; step(); check("R9 completing", phase, 3);
    hs_ack = 1'b0; step(); check("R9 idle", phase, 0);
    check("R9 acc count", acc_cnt, 1);
    check("R9 no flags", err, 0);

    // R10: refuse path, level restored while refuse is high
    hs_lvl = 4'd9; hs_req = 1'b1; step(); check("R10 requested", phase, 1);
    hs_nak = 1'b1; step(); check("R10 refused", phase, 4);
    hs_req = 1'b0; hs_lvl = 4'd5; step(); check("R10 continuing", phase, 5);
    hs_nak = 1'b0; step(); check("R10 idle", phase, 0);
    check("R10 refuse count", den_cnt, 1);
    check("R10 acc count unchanged", acc_cnt, 1);
    check("R10 no flags", err, 0);

    // R9: two more accepts back to back
    for (int k = 0; k < 2; k++) begin
      hs_req = 1'b1; step(); hs_ack = 1'b1; step();
      hs_req = 1'b0; step(); hs_ack = 1'b0; step();
    end
    check("R9 acc count after three", acc_cnt, 3);
    check("R9 no flags after three", err, 0);

    // R11: both high gives fault, release returns to idle without counting
    hs_req = 1'b1; step();
    hs_ack = 1'b1; hs_nak = 1'b1; step();
    check("R11 fault phase", phase, 6);
    check("R7 both-high flag", err[7], 1);
    hs_ack = 1'b0; hs_nak = 1'b0; step();
    check("R11 still fault while request high", phase, 6);
    hs_req = 1'b0; step();
    check("R11 back to idle", phase, 0);
    check("R11 acc count unchanged", acc_cnt, 3);
    check("R11 refuse count unchanged", den_cnt, 1);

    // R8: flags persist, clear wipes, a breach in the clear cycle survives
    step(); step();
    check("R8 sticky hold", err[7], 1);
    clr = 1'b1; hs_ack = 1'b1; step();
    check("R8 breach beats clear", err, 8'h08);
    hs_ack = 1'b0; step();
    check("R8 clear empties flags", err, 0);
    clr = 1'b0; step();
    check("R8 stays clear", err, 0);

    // R2 R3 R4 R5 R6 R7: exhaustive edge sweep over start/end combinations
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        for (int lc = 0; lc < 2; lc++) begin
          logic [7:0] base;
          logic [7:0] want;
          drive(3'(a)); clr = 1'b0; step();
          clr = 1'b1; step();
          base = (a[1] && a[0]) ? 8'h80 : 8'h00;
          check("R8 after clear", err, base);
          clr = 1'b0;
          drive(3'(b));
          if (lc != 0) hs_lvl = hs_lvl ^ 4'd1;
          step();
          want = base | exp_rules(3'(a), 3'(b), lc != 0);
          for (int i = 0; i < 8; i++) begin
            n_chk++;
            if (err[i] != want[i]) begin
              n_fail++;
              $display("FAIL %s bit %0d from %03b to %03b lvl %0d actual=%0b expected=%0b",
                       rtag(i), i, 3'(a), 3'(b), lc, err[i], want[i]);
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule